// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits between a simple request/acknowledge port and the serial side of an on-chip user flash array. A request carries an opcode, a word address and, for a program, a write word. The sequencer shifts the address into the array's address register, most significant bit first. It uses a dedicated shift clock and shift-enable for this. For a program it then shifts the write word into the array's data register in the same way, over a second clock and enable pair. For a read it shifts the data register out instead. Program and erase finish with a strobe to the array and a supervised busy handshake.

All serial timing and every handshake window is counted on the system clock. The counts are derived from nanosecond parameters and rounded up to whole cycles. The busy signal from the array is first brought through a two-flop synchronizer. The sequencer aborts a program or erase in two cases: the array never answers the strobe, or busy stays high longer than the limit for that operation. In either case it drops the strobe, sets a sticky error flag and acknowledges.

Top module: `nvm_pe_seq`

## Requirements
- R1: A request shifts AW address bits (MSB first) on the address path. A program then shifts DW write bits (MSB first) on the data path. An erase makes no data-path clocks.
- R2: Each shift clock has a period of at least SCLK_PERIOD_NS. With the defaults this is 10 cycles low and 10 cycles high at 5 ns per cycle.
- R3: Shift-enable and serial data are stable for at least SETUP_NS before every rising shift-clock edge. They stay stable for at least HOLD_NS after it.
- R4: A read (opcode 2'b00) shifts the address in, then clocks DW bits out of the data path. Each bit is sampled in the last cycle before a rising edge, MSB first. The word appears on rdata with the acknowledge, and no strobe is raised.
- R5: A program (2'b01) or erase (2'b10) raises its strobe after shifting. The strobe is released only after synchronized busy has been low for at least REL_NS. The acknowledge is a single-cycle pulse in the first cycle the strobe is low.
- R6: If synchronized busy has not risen within RESP_NS (plus two synchronizer cycles) of the strobe rising, the strobe drops, err sets and ack pulses.
- R7: If busy stays high longer than PROG_MAX_NS for a program or ERASE_MAX_NS for an erase, the strobe drops, err sets and ack pulses. The two limits are distinct.
- R8: err is sticky: later successful operations do not clear it, only reset does.
- R9: A request is accepted only while idle. A req pulse during an operation is ignored and starts no second shift.
- R10: After reset, ack, err, both strobes, both shift clocks and both shift-enables are low.
- R11: At most one strobe is high at a time: the program strobe for 2'b01, the erase strobe for 2'b10. Opcode 2'b11 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, sampled while idle |
| op | input | 2 | Opcode: 00 read, 01 program, 10 erase, 11 read |
| addr | input | AW | Word address |
| wdata | input | DW | Word to program |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Word from the last read |
| err | output | 1 | Sticky timeout flag |
| a_clk | output | 1 | Address shift clock |
| a_shift | output | 1 | Address shift enable |
| a_sdi | output | 1 | Address serial data |
| d_clk | output | 1 | Data shift clock |
| d_shift | output | 1 | Data shift enable |
| d_sdi | output | 1 | Data serial data into the array |
| d_sdo | input | 1 | Data serial data from the array |
| prog | output | 1 | Program strobe |
| erase | output | 1 | Erase strobe |
| busy | input | 1 | Array busy |

## Verification
Assertions check the following on every cycle:
- the strobes never overlap;
- a strobe only falls after a release or a fault;
- the acknowledge is a single pulse;
- the error flag never clears;
- shifting only starts from idle;
- the serial data never moves across a rising shift-clock edge;
- the window counters stay within their limits.

Only the bench's scenarios can show the rest, using a behavioural array model and time-stamp monitors:
- that the shifted words land MSB first at the right address;
- that read data is sampled correctly;
- that the clock period and setup/hold hold in nanoseconds;
- that the response and maximum-busy windows end the strobe at the intended times;
- that the program and erase limits differ.

// File: rtl/nvm_seq_pkg.sv
`timescale 1ns/1ps
package nvm_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'b00, OP_PROG = 2'b01, OP_ERASE = 2'b10, OP_RSVD = 2'b11} op_e;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_STRB, S_BUSY, S_FIN} st_e;

  // whole cycles needed to cover a span, rounded up
  function automatic int ns2cyc(input int ns, input int per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvm_seq_shift.sv
`timescale 1ns/1ps
module nvm_seq_shift import nvm_seq_pkg::*; #(
  parameter int W  = 9,
  parameter int LO = 10,
  parameter int HI = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         sclk,
  output logic         sen,
  output logic         sdi,
  output logic         rise,
  output logic         done
);
  localparam int PW = $clog2(imax(LO, HI) + 1);
  localparam int BW = $clog2(W + 1);

  logic          act, ph;
  logic [PW-1:0] pc;
  logic [BW-1:0] bc;
  logic [W-1:0]  sr;
  logic          last_lo, last_hi;

  assign last_lo = act && !ph && (pc == PW'(LO - 1));
  assign last_hi = act &&  ph && (pc == PW'(HI - 1));
  assign rise    = last_lo;
  assign done    = last_hi && (bc == BW'(W - 1));
  assign sclk    = act && ph;
  assign sen     = act;
  assign sdi     = sr[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; ph <= 1'b0; pc <= '0; bc <= '0; sr <= '0;
    end else if (start) begin
      act <= 1'b1; ph <= 1'b0; pc <= '0; bc <= '0; sr <= load;
    end else if (act) begin
      if (last_lo) begin
        ph <= 1'b1; pc <= '0;
      end else if (last_hi) begin
        ph <= 1'b0; pc <= '0;
        sr <= {sr[W-2:0], 1'b0};
        if (done) act <= 1'b0;
        else      bc  <= bc + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // R3
  sdi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> ($past(sen) && $stable(sdi)));
  // R3
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdi));
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !sen);
endmodule

// File: rtl/nvm_seq_watch.sv
`timescale 1ns/1ps
module nvm_seq_watch #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [LW-1:0] lim,
  output logic          hit
);
  logic [LW-1:0] cnt;

  assign hit = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
endmodule

// File: rtl/nvm_pe_seq.sv
`timescale 1ns/1ps
module nvm_pe_seq import nvm_seq_pkg::*; #(
  parameter int AW             = 9,
  parameter int DW             = 16,
  parameter int CLK_NS         = 5,
  parameter int SCLK_PERIOD_NS = 100,
  parameter int SETUP_NS       = 20,
  parameter int HOLD_NS        = 20,
  parameter int RESP_NS        = 960,
  parameter int REL_NS         = 20,
  parameter int PROG_MAX_NS    = 100_000,
  parameter int ERASE_MAX_NS   = 500_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          a_clk,
  output logic          a_shift,
  output logic          a_sdi,
  output logic          d_clk,
  output logic          d_shift,
  output logic          d_sdi,
  input  logic          d_sdo,
  output logic          prog,
  output logic          erase,
  input  logic          busy
);
  localparam int SYNC   = 2;
  localparam int HALF   = ns2cyc(SCLK_PERIOD_NS, 2 * CLK_NS);
  localparam int LO_C   = imax(HALF, ns2cyc(SETUP_NS, CLK_NS));
  localparam int HI_C   = imax(HALF, ns2cyc(HOLD_NS, CLK_NS));
  localparam int RESP_L = ns2cyc(RESP_NS, CLK_NS) + SYNC;
  localparam int REL_C  = imax(1, ns2cyc(REL_NS, CLK_NS));
  localparam int PMAX_C = ns2cyc(PROG_MAX_NS, CLK_NS);
  localparam int EMAX_C = ns2cyc(ERASE_MAX_NS, CLK_NS);
  localparam int RW     = $clog2(RESP_L + 1);
  localparam int LWR    = $clog2(REL_C + 1);
  localparam int DURW   = $clog2(imax(PMAX_C, EMAX_C) + 1);

  st_e           st;
  op_e           op_q;
  logic [DW-1:0] wdata_q, rcap, rdata_q;
  logic          err_q, b_m, b_s;
  logic          is_prog, is_erase, strb_on;
  logic          a_start, a_rise, a_done, d_start, d_rise, d_done;
  logic          resp_hit, dur_hit, low_hit;
  logic          resp_to, busy_over, rel_ok, fault;
  logic [DURW-1:0] dur_lim;

  assign is_prog  = (op_q == OP_PROG);
  assign is_erase = (op_q == OP_ERASE);
  assign strb_on  = (st == S_STRB) || (st == S_BUSY);
  assign prog     = strb_on && is_prog;
  assign erase    = strb_on && is_erase;
  assign a_start  = (st == S_IDLE) && req;
  assign d_start  = (st == S_ADDR) && a_done && !is_erase;
  assign dur_lim  = is_erase ? DURW'(EMAX_C) : DURW'(PMAX_C);

  // named handshake events
  assign resp_to   = (st == S_STRB) && resp_hit && !b_s;
  assign busy_over = (st == S_BUSY) && dur_hit && b_s;
  assign rel_ok    = (st == S_BUSY) && low_hit && !b_s;
  assign fault     = resp_to || busy_over;

  nvm_seq_shift #(.W(AW), .LO(LO_C), .HI(HI_C)) u_ash (
    .clk(clk), .rst_n(rst_n), .start(a_start), .load(addr),
    .sclk(a_clk), .sen(a_shift), .sdi(a_sdi), .rise(a_rise), .done(a_done));

  nvm_seq_shift #(.W(DW), .LO(LO_C), .HI(HI_C)) u_dsh (
    .clk(clk), .rst_n(rst_n), .start(d_start), .load(is_prog ? wdata_q : '0),
    .sclk(d_clk), .sen(d_shift), .sdi(d_sdi), .rise(d_rise), .done(d_done));

  nvm_seq_watch #(.LW(RW)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr(st != S_STRB), .en(1'b1),
    .lim(RW'(RESP_L)), .hit(resp_hit));

  nvm_seq_watch #(.LW(DURW)) u_dur (
    .clk(clk), .rst_n(rst_n), .clr(st != S_BUSY), .en(b_s),
    .lim(dur_lim), .hit(dur_hit));

  nvm_seq_watch #(.LW(LWR)) u_low (
    .clk(clk), .rst_n(rst_n), .clr((st != S_BUSY) || b_s), .en(1'b1),
    .lim(LWR'(REL_C)), .hit(low_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_m <= 1'b0; b_s <= 1'b0;
    end else begin
      b_m <= busy; b_s <= b_m;
    end
  end

  // read bit is taken in the last low cycle, long after the previous edge
  always_ff @(posedge clk) begin
    if (!rst_n)      rcap <= '0;
    else if (d_rise) rcap <= {rcap[DW-2:0], d_sdo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_READ; wdata_q <= '0; rdata_q <= '0; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          op_q <= op_e'(op); wdata_q <= wdata; st <= S_ADDR;
        end
        S_ADDR: if (a_done) st <= is_erase ? S_STRB : S_DATA;
        S_DATA: if (d_done) begin
          if (is_prog) st <= S_STRB;
          else begin rdata_q <= rcap; st <= S_FIN; end
        end
        S_STRB: if (b_s) st <= S_BUSY;
                else if (resp_to) begin err_q <= 1'b1; st <= S_FIN; end
        S_BUSY: if (busy_over) begin err_q <= 1'b1; st <= S_FIN; end
                else if (rel_ok) st <= S_FIN;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack   = (st == S_FIN);
  assign rdata = rdata_q;
  assign err   = err_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog, erase}));
  // R5
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog || erase) |-> ($past(rel_ok) || $past(fault)));
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_shift) |-> ($past(st) == S_IDLE));
  // R3
  a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rise |-> (a_shift && !a_clk));
endmodule

// File: tb/nvm_pe_seq_tb.sv
`timescale 1ns/1ps
module nvm_pe_seq_tb;
  localparam int AW = 9;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] op = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ack, err, a_clk, a_shift, a_sdi, d_clk, d_shift, d_sdi, d_sdo, prog, erase;
  logic [DW-1:0] rdata;
  logic busy;

  always #2.5 clk = ~clk;

  nvm_pe_seq #(.AW(AW), .DW(DW), .ERASE_MAX_NS(200_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .err(err), .a_clk(a_clk), .a_shift(a_shift),
    .a_sdi(a_sdi), .d_clk(d_clk), .d_shift(d_shift), .d_sdi(d_sdi), .d_sdo(d_sdo),
    .prog(prog), .erase(erase), .busy(busy));

  int nchk = 0, nbad = 0;

  // ---------------- array model ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] m_areg = '0;
  logic [DW-1:0] m_dreg = '0;
  int a_bits = 0, d_bits = 0, ops = 0, last_kind = 0;
  int rdly = 30, blen = 300;
  bit no_resp = 1'b0;
  bit ok_run;

  assign d_sdo = m_dreg[DW-1];

  always @(posedge a_clk) if (a_shift) begin
    m_areg <= {m_areg[AW-2:0], a_sdi};
    a_bits++;
  end

  always @(posedge d_clk or negedge a_shift) begin
    if (d_clk && d_shift) begin
      m_dreg <= {m_dreg[DW-2:0], d_sdi};
      d_bits++;
    end else if (!a_shift) begin
      m_dreg <= mem[m_areg];
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    busy = 1'b0;
    forever begin
      @(negedge clk);
      if (prog || erase) begin
        ops++;
        last_kind = erase ? 2 : 1;
        if (no_resp) wait (!prog && !erase);
        else begin
          repeat (rdly) @(negedge clk);
          busy = 1'b1; ok_run = 1'b1;
          for (int i = 0; i < blen; i++) begin
            @(negedge clk);
            if (!prog && !erase) begin ok_run = 1'b0; break; end
          end
          busy = 1'b0;
          if (ok_run) begin
            if (last_kind == 2) mem[m_areg] = '1;
            else                mem[m_areg] = m_dreg;
          end
          wait (!prog && !erase);
        end
      end
    end
  end

  // ---------------- timing monitors ----------------
  realtime t_sr = 0, s_dur = 0, t_bf = -1.0e6;
  int rel_viol = 0;
  always @(negedge busy) t_bf = $realtime;
  always @(posedge prog or posedge erase) t_sr = $realtime;
  always @(negedge prog or negedge erase) begin
    s_dur = $realtime - t_sr;
    if (!busy && ($realtime - t_bf) < 20.0) rel_viol++;
  end

  realtime ta_r = -1.0e6, ta_c = -1.0e6, ta_min = 1.0e9;
  int a_su = 0, a_ho = 0;
  always @(posedge a_clk) begin
    if (ta_r > 0) ta_min = ($realtime - ta_r < ta_min) ? $realtime - ta_r : ta_min;
    if ($realtime - ta_c < 20.0) a_su++;
    ta_r = $realtime;
  end
  always @(a_sdi or a_shift) begin
    if ($realtime - ta_r < 20.0) a_ho++;
    ta_c = $realtime;
  end

  realtime td_r = -1.0e6, td_c = -1.0e6, td_min = 1.0e9;
  int d_su = 0, d_ho = 0;
  always @(posedge d_clk) begin
    if (td_r > 0) td_min = ($realtime - td_r < td_min) ? $realtime - td_r : td_min;
    if ($realtime - td_c < 20.0) d_su++;
    td_r = $realtime;
  end
  always @(d_sdi or d_shift) begin
    if ($realtime - td_r < 20.0) d_ho++;
    td_c = $realtime;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_req(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = w;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_ack();
    int n = 0;
    while (!ack && n < 150000) begin @(negedge clk); n++; end
    chk(ack, "R5 ack seen", 32'(ack), 1);
    @(negedge clk);
    chk(!ack, "R5 ack single cycle", 32'(ack), 0);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    send_req(o, a, w);
    wait_ack();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk({ack, err, prog, erase, a_clk, d_clk, a_shift, d_shift} == 8'h00,
        "R10 reset outputs", 32'({ack, err, prog, erase, a_clk, d_clk, a_shift, d_shift}), 0);
  endtask

  task automatic t_prog_read(input logic [AW-1:0] a, input logic [DW-1:0] w);
    int ab = a_bits, db = d_bits, o0;
    run_op(2'b01, a, w);
    chk(mem[a] == w, "R1 programmed word", 32'(mem[a]), 32'(w));
    chk(a_bits - ab == AW && d_bits - db == DW, "R1 bit counts",
        32'((a_bits - ab) * 256 + (d_bits - db)), 32'(AW * 256 + DW));
    chk(last_kind == 1, "R11 program strobe used", 32'(last_kind), 1);
    chk(!err, "R5 no error on good program", 32'(err), 0);
    o0 = ops;
    run_op(2'b00, a, 16'h0);
    chk(rdata == w, "R4 read back", 32'(rdata), 32'(w));
    chk(ops == o0, "R4 read raises no strobe", 32'(ops), 32'(o0));
  endtask

  task automatic t_erase(input logic [AW-1:0] a);
    int db = d_bits;
    run_op(2'b10, a, 16'h1234);
    chk(mem[a] == 16'hFFFF, "R1 erased word", 32'(mem[a]), 32'hFFFF);
    chk(d_bits == db, "R1 erase makes no data clocks", 32'(d_bits - db), 0);
    chk(last_kind == 2, "R11 erase strobe used", 32'(last_kind), 2);
  endtask

  task automatic t_rsvd_op(input logic [AW-1:0] a);
    int o0 = ops;
    run_op(2'b11, a, 16'h0);
    chk(rdata == mem[a], "R11 opcode 11 reads", 32'(rdata), 32'(mem[a]));
    chk(ops == o0, "R11 opcode 11 no strobe", 32'(ops), 32'(o0));
  endtask

  task automatic t_req_while_busy();
    int ab = a_bits, o0 = ops;
    logic [DW-1:0] m7 = mem[7];
    send_req(2'b01, 9'd5, 16'h1234);
    repeat (60) @(negedge clk);
    req = 1'b1; op = 2'b10; addr = 9'd7;
    @(negedge clk);
    req = 1'b0;
    wait_ack();
    repeat (100) @(negedge clk);
    chk(a_bits - ab == AW, "R9 single address shift", 32'(a_bits - ab), AW);
    chk(ops - o0 == 1, "R9 single strobe", 32'(ops - o0), 1);
    chk(mem[5] == 16'h1234 && mem[7] == m7, "R9 only first request done",
        32'({mem[5], mem[7]}), 32'({16'h1234, m7}));
  endtask

  task automatic t_no_response();
    logic [DW-1:0] m3 = mem[3];
    no_resp = 1'b1;
    run_op(2'b01, 9'd3, 16'h5555);
    no_resp = 1'b0;
    chk(err, "R6 error on missing busy", 32'(err), 1);
    chk(mem[3] == m3, "R6 word untouched", 32'(mem[3]), 32'(m3));
    chk(s_dur >= 960.0 && s_dur <= 1100.0, "R6 strobe window", 32'(int'(s_dur)), 960);
    chk(!prog, "R6 strobe dropped", 32'(prog), 0);
  endtask

  task automatic t_sticky();
    run_op(2'b01, 9'd9, 16'hA5A5);
    chk(mem[9] == 16'hA5A5, "R8 later program works", 32'(mem[9]), 32'hA5A5);
    chk(err, "R8 error stays set", 32'(err), 1);
    do_reset();
    chk(!err, "R10 reset clears error", 32'(err), 0);
  endtask

  task automatic t_long_prog();
    logic [DW-1:0] m4 = mem[4];
    blen = 30000;
    run_op(2'b01, 9'd4, 16'h0F0F);
    blen = 300;
    chk(err, "R7 program busy too long", 32'(err), 1);
    chk(s_dur >= 100000.0 && s_dur <= 100400.0, "R7 program limit time",
        32'(int'(s_dur)), 100000);
    chk(mem[4] == m4, "R7 aborted program no write", 32'(mem[4]), 32'(m4));
    do_reset();
  endtask

  task automatic t_erase_limits();
    logic [DW-1:0] m8;
    blen = 25000;
    run_op(2'b10, 9'd6, 16'h0);
    chk(!err && mem[6] == 16'hFFFF, "R7 erase beyond program limit accepted",
        32'({err, mem[6]}), 32'hFFFF);
    run_op(2'b01, 9'd8, 16'h00FF);
    m8 = mem[8];
    blen = 50000;
    run_op(2'b10, 9'd8, 16'h0);
    blen = 300;
    chk(err, "R7 erase busy too long", 32'(err), 1);
    chk(s_dur >= 200000.0 && s_dur <= 200400.0, "R7 erase limit time",
        32'(int'(s_dur)), 200000);
    chk(mem[8] == m8, "R7 aborted erase no change", 32'(mem[8]), 32'(m8));
  endtask

  task automatic t_timing();
    chk(ta_min >= 100.0, "R2 address clock period", 32'(int'(ta_min)), 100);
    chk(td_min >= 100.0, "R2 data clock period", 32'(int'(td_min)), 100);
    chk(a_su + d_su == 0, "R3 setup violations", 32'(a_su + d_su), 0);
    chk(a_ho + d_ho == 0, "R3 hold violations", 32'(a_ho + d_ho), 0);
    chk(rel_viol == 0, "R5 release after busy low", 32'(rel_viol), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++; nchk++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_prog_read(9'h1A5, 16'hBEEF);
    t_prog_read(9'h000, 16'h8001);
    t_prog_read(9'h1FF, 16'h7FFE);
    t_erase(9'h1A5);
    t_rsvd_op(9'h000);
    t_req_while_busy();
    t_no_response();
    t_sticky();
    t_long_prog();
    t_erase_limits();
    t_timing();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule